// File: doc/BRIEF.md
# Floating-Point Exception Status and Control Register

This block holds the status and control word of a floating-point unit. It keeps the rounding-mode selection, the denormal-flush switch, a per-operation cause field, a sticky flag field and a trap-enable field. Each exception field covers the five IEEE exceptions. The arithmetic core reports a raw 5-bit exception vector when it completes an operation. The block then replaces the cause field with that vector and ORs the same bits into the sticky flags. When the new cause bits meet a set enable bit, it requests a trap with a fixed exception code.

Software loads the whole word through a write port. Unimplemented bits are masked off. The block decodes the stored rounding mode and flush bit into two steady control lines for the arithmetic core. For the approximate reciprocal-square-root operation, an operation that reports no exception is marked as inexact. Other exception reports from that operation pass through unchanged.

Within every exception field, the bit order from high to low is invalid (V), divide-by-zero (Z), overflow (O), underflow (U), inexact (I). The word is laid out as follows:

- Bits 1:0 hold the rounding mode.
- Bits 6:2 hold the sticky flags.
- Bits 11:7 hold the enables.
- Bits 16:12 hold the cause.
- Bit 17 is an extra cause bit.
- Bit 18 is the denormal-flush switch.
- Bits 31:19 always read as zero.

Top module: `fpsr_ctrl`

## Requirements
- R1: While reset is held, and right after reset, `csr_q` is zero, `trap_req` is low and `trap_code` is zero.
- R2: An update (`upd_valid` high, `wr_en` low) loads the effective exception vector into bits 16:12 (V at 16, I at 12) and clears bit 17. The result is visible one cycle later.
- R3: An update ORs the effective vector into the flags at bits 6:2 (V at 6, I at 2). Flag bits that are already set are never cleared by an update.
- R4: Consider the AND of the new cause bits with the enables at bits 11:7. If it is non-zero, `trap_req` is high for exactly the next cycle with `trap_code` = 0x120. Otherwise `trap_req` stays low and `trap_code` is 0. Set flags whose cause is not current never cause a trap.
- R5: An update whose effective vector is zero clears the cause bits 17:12 and raises no trap. It leaves bits 11:0 and bit 18 unchanged.
- R6: A write (`wr_en` high) stores `wr_data` AND 0x0007FFFF one cycle later. A write never raises a trap, even if the written cause and enable bits overlap.
- R7: When `wr_en` and `upd_valid` are high in the same cycle, the write is applied and the update is discarded. This includes its trap.
- R8: `rnd_trunc` is high exactly when bits 1:0 of the stored word equal 01 (round toward zero). The encodings 00, 10 and 11 all select round-to-nearest-even (`rnd_trunc` low).
- R9: `flush_den` follows bit 18 of the stored word.
- R10: With `upd_approx` high, an all-zero raw vector becomes inexact only (00001). Any non-zero raw vector is used unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| upd_valid | input | 1 | An arithmetic operation completed this cycle |
| upd_exc | input | 5 | Raw exception vector {V,Z,O,U,I} |
| upd_approx | input | 1 | The completed operation was an approximate reciprocal square root |
| wr_en | input | 1 | Software load of the word |
| wr_data | input | 32 | Value to load |
| csr_q | output | 32 | Stored status and control word |
| rnd_trunc | output | 1 | Arithmetic core rounds toward zero |
| flush_den | output | 1 | Arithmetic core flushes denormals to zero |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 12 | Exception code, 0x120 while trap_req is high, else 0 |

## Verification
The update path is driven with these patterns:

- A single exception, followed by a different single exception. This shows that the cause field is replaced while the flags accumulate.
- An all-zero vector after flags are set. This separates clearing of the cause from clearing of the flags.
- An all-ones vector with every enable set.

For the trap path, the same enable setting is paired with matching and non-matching causes. A zero-cause update after a sticky flag shows that only the current cause is tested. Writes that contain overlapping cause and enable bits, and a write that collides with an update, show that only updates trap and that writes take priority. The rounding encodings 00 to 11, the flush bit, and approximate operations with zero and non-zero vectors complete the decode and forcing cases.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int EXC_W     = 5;
  localparam int CSR_W     = 32;
  localparam int RM_W      = 2;
  localparam int RM_LO     = 0;
  localparam int FLAG_LO   = RM_LO + RM_W;
  localparam int ENA_LO    = FLAG_LO + EXC_W;
  localparam int CAUSE_LO  = ENA_LO + EXC_W;
  localparam int CAUSE_W   = EXC_W + 1;
  localparam int CAUSE_HI  = CAUSE_LO + CAUSE_W - 1;
  localparam int DEN_BIT   = CAUSE_HI + 1;
  localparam int USED_W    = DEN_BIT + 1;
  localparam logic [CSR_W-1:0] WR_MASK = CSR_W'((64'd1 << USED_W) - 64'd1);
  localparam int CODE_W    = 12;
  localparam logic [CODE_W-1:0] TRAP_CODE = 12'h120;

  typedef enum logic [RM_W-1:0] {
    RM_NEAREST = 2'b00,
    RM_TOZERO  = 2'b01,
    RM_RSVD2   = 2'b10,
    RM_RSVD3   = 2'b11
  } rmode_e;

  // bit index of each exception inside a field
  localparam int EX_I = 0;
  localparam int EX_U = 1;
  localparam int EX_O = 2;
  localparam int EX_Z = 3;
  localparam int EX_V = 4;
endpackage

// File: rtl/fpsr_exc_shape.sv
// Turns the raw exception report into the vector used for the update (R10).
module fpsr_exc_shape #(
  parameter int EXC_W = 5,
  parameter int INEXACT_IDX = 0
) (
  input  logic [EXC_W-1:0] raw_exc,
  input  logic             approx_op,
  output logic [EXC_W-1:0] eff_exc
);
  localparam logic [EXC_W-1:0] ONLY_INEXACT = EXC_W'(1) << INEXACT_IDX;

  always_comb begin
    eff_exc = raw_exc;
    if (approx_op && (raw_exc == '0)) begin
      eff_exc = ONLY_INEXACT;
    end
  end
endmodule

// File: rtl/fpsr_trap_eval.sv
// Trap decision from the current cause bits only (R4).
module fpsr_trap_eval #(
  parameter int EXC_W = 5
) (
  input  logic [EXC_W-1:0] new_cause,
  input  logic [EXC_W-1:0] enables,
  output logic             trap_hit
);
  logic [EXC_W-1:0] hit_vec;

  for (genvar g = 0; g < EXC_W; g++) begin : g_hit
    assign hit_vec[g] = new_cause[g] & enables[g];
  end

  assign trap_hit = |hit_vec;
endmodule

// File: rtl/fpsr_mode_dec.sv
// Decodes the stored word into controls for the arithmetic core (R8, R9).
module fpsr_mode_dec #(
  parameter int CSR_W   = 32,
  parameter int RM_LO   = 0,
  parameter int DEN_BIT = 18
) (
  input  logic [CSR_W-1:0] csr_word,
  output logic             rnd_trunc,
  output logic             flush_den
);
  import fpsr_pkg::*;

  rmode_e rm;

  always_comb begin
    rm        = rmode_e'(csr_word[RM_LO +: RM_W]);
    rnd_trunc = 1'b0;
    case (rm)
      RM_TOZERO: rnd_trunc = 1'b1;
      default:   rnd_trunc = 1'b0;
    endcase
    flush_den = csr_word[DEN_BIT];
  end
endmodule

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
  import fpsr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_valid,
  input  logic [EXC_W-1:0]     upd_exc,
  input  logic                 upd_approx,
  input  logic                 wr_en,
  input  logic [CSR_W-1:0]     wr_data,
  output logic [CSR_W-1:0]     csr_q,
  output logic                 rnd_trunc,
  output logic                 flush_den,
  output logic                 trap_req,
  output logic [CODE_W-1:0]    trap_code
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_s_n = rst_pipe[1];

  logic [EXC_W-1:0] eff_exc;
  logic             trap_hit;
  logic [CSR_W-1:0] csr_d;
  logic             csr_en;
  logic             trap_d;
  logic             upd_take;

  fpsr_exc_shape #(.EXC_W(EXC_W), .INEXACT_IDX(EX_I)) u_shape (
    .raw_exc   (upd_exc),
    .approx_op (upd_approx),
    .eff_exc   (eff_exc)
  );

  fpsr_trap_eval #(.EXC_W(EXC_W)) u_trap (
    .new_cause (eff_exc),
    .enables   (csr_q[ENA_LO +: EXC_W]),
    .trap_hit  (trap_hit)
  );

  fpsr_mode_dec #(.CSR_W(CSR_W), .RM_LO(RM_LO), .DEN_BIT(DEN_BIT)) u_mode (
    .csr_word  (csr_q),
    .rnd_trunc (rnd_trunc),
    .flush_den (flush_den)
  );

  // next state
  assign upd_take = upd_valid & ~wr_en;
  assign csr_en   = wr_en | upd_valid;

  always_comb begin
    csr_d  = csr_q;
    trap_d = 1'b0;
    if (wr_en) begin
      csr_d = wr_data & WR_MASK;
    end else if (upd_valid) begin
      csr_d[CAUSE_HI:CAUSE_LO]   = {1'b0, eff_exc};
      csr_d[FLAG_LO +: EXC_W]    = csr_q[FLAG_LO +: EXC_W] | eff_exc;
      trap_d                     = trap_hit;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      csr_q    <= '0;
      trap_req <= 1'b0;
    end else begin
      if (csr_en) begin
        csr_q <= csr_d;
      end
      trap_req <= trap_d;
    end
  end

  assign trap_code = trap_req ? TRAP_CODE : '0;

  // checks
  a_r2_cause_load: assert property (@(posedge clk) disable iff (!rst_s_n)
    upd_take |=> (csr_q[CAUSE_LO +: EXC_W] == $past(eff_exc)) && !csr_q[CAUSE_HI]);

  a_r3_flags_sticky: assert property (@(posedge clk) disable iff (!rst_s_n)
    upd_take |=> ((csr_q[FLAG_LO +: EXC_W] & $past(csr_q[FLAG_LO +: EXC_W]))
                  == $past(csr_q[FLAG_LO +: EXC_W])));

  a_r4_trap_from_update: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(trap_req) |-> $past(upd_take));

  a_r5_quiet_no_trap: assert property (@(posedge clk) disable iff (!rst_s_n)
    (upd_take && (eff_exc == '0)) |=> !trap_req && (csr_q[ENA_LO +: EXC_W] == $past(csr_q[ENA_LO +: EXC_W])));

  a_r6_write_masked: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_en |=> (csr_q == $past(wr_data & WR_MASK)) && !trap_req);

  a_r10_approx_inexact: assert property (@(posedge clk) disable iff (!rst_s_n)
    (upd_approx && (upd_exc == '0)) |-> $onehot0(eff_exc) && eff_exc[EX_I]);

endmodule

// File: tb/tb_fpsr_ctrl.sv
module tb_fpsr_ctrl;
  logic        clk;
  logic        rst_n;
  logic        upd_valid;
  logic [4:0]  upd_exc;
  logic        upd_approx;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] csr_q;
  logic        rnd_trunc;
  logic        flush_den;
  logic        trap_req;
  logic [11:0] trap_code;

  fpsr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_exc(upd_exc),
    .upd_approx(upd_approx), .wr_en(wr_en), .wr_data(wr_data), .csr_q(csr_q),
    .rnd_trunc(rnd_trunc), .flush_den(flush_den), .trap_req(trap_req),
    .trap_code(trap_code)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] csr;
    logic        trap;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  exp_t        it;
  logic [31:0] model;
  int          n_chk  = 0;
  int          n_fail = 0;
  logic        mon_on = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] ex);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, ex);
    end
  endtask

  // driver: one transaction, one idle cycle
  task automatic drive(input bit w, input logic [31:0] d, input bit u,
                       input logic [4:0] e, input bit ap, input string tag);
    logic [4:0] eff;
    bit         tr;
    exp_t       x;
    @(negedge clk);
    wr_en = w; wr_data = d; upd_valid = u; upd_exc = e; upd_approx = ap;
    eff = (ap && e == 5'd0) ? 5'b00001 : e;
    tr  = 1'b0;
    if (w) begin
      model = d & 32'h0007_FFFF;
    end else if (u) begin
      tr = |(eff & model[11:7]);
      model[17:12] = {1'b0, eff};
      model[6:2]   = model[6:2] | eff;
    end
    x.csr = model; x.trap = tr; x.tag = tag;
    sb.push_back(x);
    @(negedge clk);
    wr_en = 1'b0; upd_valid = 1'b0; upd_exc = '0; upd_approx = 1'b0;
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check(csr_q == it.csr, {it.tag, " word"}, csr_q, it.csr);
        check(trap_req == it.trap && trap_code == (it.trap ? 12'h120 : 12'h0),
              {it.tag, " R4 trap"}, {19'd0, trap_req, trap_code}, {19'd0, it.trap, it.trap ? 12'h120 : 12'h0});
        check(rnd_trunc == (it.csr[1:0] == 2'b01), {it.tag, " R8 rounding"},
              {31'd0, rnd_trunc}, {31'd0, it.csr[1:0] == 2'b01});
        check(flush_den == it.csr[18], {it.tag, " R9 flush"}, {31'd0, flush_den}, {31'd0, it.csr[18]});
      end else begin
        check(!trap_req && csr_q == model, "R4 pulse ends / idle hold",
              {trap_req, csr_q[30:0]}, {1'b0, model[30:0]});
      end
    end
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; upd_valid = 1'b0;
    upd_exc = '0; upd_approx = 1'b0; model = '0;
    repeat (3) @(negedge clk);
    check(csr_q == 32'd0 && !trap_req && trap_code == 12'd0, "R1 reset held", csr_q, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(csr_q == 32'd0 && !trap_req && !rnd_trunc, "R1 after reset", csr_q, 32'd0);
    mon_on = 1'b1;

    drive(1, 32'hFFFF_FFFF, 0, 5'd0, 0, "R6 masked write, no trap");
    drive(1, 32'h0000_0000, 0, 5'd0, 0, "R6 clear write");
    drive(1, 32'h0000_0001, 0, 5'd0, 0, "R8 rm=01");
    drive(1, 32'h0000_0002, 0, 5'd0, 0, "R8 rm=10");
    drive(1, 32'h0004_0003, 0, 5'd0, 0, "R9 flush rm=11");
    drive(1, 32'h0000_0000, 0, 5'd0, 0, "R6 clear");
    drive(0, 32'd0, 1, 5'b10000, 0, "R2 cause V");
    drive(0, 32'd0, 1, 5'b00001, 0, "R3 cause I flags keep V");
    drive(0, 32'd0, 1, 5'b00000, 0, "R5 zero clears cause");
    drive(1, 32'h0002_0800, 0, 5'd0, 0, "R6 write extra cause, enable V");
    drive(0, 32'd0, 1, 5'b00000, 0, "R5 extra cause cleared");
    drive(0, 32'd0, 1, 5'b10000, 0, "R4 enabled V traps");
    drive(0, 32'd0, 1, 5'b00001, 0, "R4 I not enabled");
    drive(0, 32'd0, 1, 5'b00000, 0, "R4 sticky V flag no trap");
    drive(0, 32'd0, 1, 5'b00000, 1, "R10 approx forces I");
    drive(0, 32'd0, 1, 5'b01000, 1, "R10 approx Z unchanged");
    drive(0, 32'd0, 1, 5'b10000, 1, "R10 approx V traps");
    drive(1, 32'h0000_0001, 1, 5'b10000, 0, "R7 write wins");
    drive(1, 32'h0001_0F80, 0, 5'd0, 0, "R6 cause and enable overlap no trap");
    drive(0, 32'd0, 1, 5'b11111, 0, "R2 all exceptions trap");
    drive(0, 32'd0, 1, 5'b00110, 0, "R3 O and U accumulate");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule